// File: doc/BRIEF.md
# Read Data Return Path with Selectable Output Register

This block sits between the array of a synchronous burst memory and its data pins and decides when read data is presented and when the pins are driven. A static mode input selects one of two timings. In flow-through timing, array data passes straight to the outputs in the cycle after the read command is sampled, so a burst returns 2-1-1-1. In registered timing, an output register captures the array data one edge later, so a burst returns 3-1-1-1.

Deselect commands use the same pipeline stages as reads. With the output register in use, the outputs therefore stay driven for one full cycle after a deselect is sampled and go quiet only after the following edge. A write command clears the read-active state at once, so the pins are never driven during a write. The output enable is asynchronous and gates the per-bit drive enable without waiting for a clock.

The command decoder supplies one command per clock on two wires. The array supplies read data during the cycle after the read command was sampled.

Top module: `sram_rd_out_path`

## Requirements
- R1: While rst_ni is low, valid_o is 0, data_o is all zeros and drive_en_o is all zeros.
- R2: With pipe_mode_i = 0, a read (sel_i = 1, rd_i = 1) sampled at edge k gives valid_o = 1 and data_o equal to the current rd_data_i during the cycle that follows edge k.
- R3: With pipe_mode_i = 1, a read sampled at edge k makes the block capture rd_data_i at edge k+1. That word appears on data_o with valid_o = 1 during the cycle after edge k+1, and not before.
- R4: Back-to-back reads return one new word per cycle in both modes, with no gap.
- R5: With pipe_mode_i = 1, a deselect (sel_i = 0) sampled at edge k that follows a read sampled at edge k-1 leaves the outputs valid and driven with that read's word during the cycle after edge k. valid_o falls after edge k+1.
- R6: With pipe_mode_i = 0, a deselect sampled at edge k makes valid_o low during the cycle after edge k.
- R7: A write (sel_i = 1, rd_i = 0) sampled at edge k makes valid_o low during the cycle after edge k in both modes. In registered mode this also discards a read sampled at edge k-1.
- R8: drive_en_o is all ones when oe_i = 1 and valid_o = 1, and all zeros otherwise. A change of oe_i takes effect without a clock edge.
- R9: data_o is all zeros whenever valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 1 selects registered timing, 0 selects flow-through; keep static while reads are in flight |
| oe_i | input | 1 | Asynchronous output enable |
| sel_i | input | 1 | Chip selected this cycle; 0 is a deselect command |
| rd_i | input | 1 | With sel_i = 1: 1 is a read, 0 is a write |
| rd_data_i | input | DATA_W | Array read data, valid in the cycle after the read is sampled |
| data_o | output | DATA_W | Read data toward the pins |
| valid_o | output | 1 | data_o carries read data this cycle |
| drive_en_o | output | DATA_W | Per-bit drive enable, stands in for tri-state control |

## Verification
A stuck or mis-cleared read-active flag shows at valid_o and drive_en_o in the first cycle after the offending edge. One example is a write that fails to flush the output stage. Another is a deselect that bypasses the output stage. Using the wrong stage for the selected mode moves a word one cycle early or late. In registered mode, the data compare exposes this within one cycle, because each burst word differs from its neighbours. A drive enable that waits for a clock shows within the same cycle in which oe_i is toggled.

// File: rtl/sram_rd_out_pkg.sv
package sram_rd_out_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic sel, input logic rd);
    if (!sel)    return CMD_DESEL;
    else if (rd) return CMD_READ;
    else         return CMD_WRITE;
  endfunction

endpackage

// File: rtl/sram_rd_cmd_stage.sv
module sram_rd_cmd_stage
  import sram_rd_out_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic rd_i,
  output logic s1_rd_o,
  output logic kill_o
);

  cmd_e cmd_now;
  logic s1_rd_q;

  assign cmd_now = decode_cmd(sel_i, rd_i);

  // Write in flight: clears every read-active stage at this edge.
  assign kill_o = (cmd_now == CMD_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_rd_q <= 1'b0;
    end else begin
      unique case (cmd_now)
        CMD_READ:  s1_rd_q <= 1'b1;
        CMD_WRITE: s1_rd_q <= 1'b0;
        default:   s1_rd_q <= 1'b0; // deselect travels like a read
      endcase
    end
  end

  assign s1_rd_o = s1_rd_q;

endmodule

// File: rtl/sram_rd_out_reg.sv
module sram_rd_out_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s1_rd_i,
  input  logic              kill_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              s2_rd_o,
  output logic [DATA_W-1:0] s2_data_o
);

  logic              s2_rd_q;
  logic [DATA_W-1:0] s2_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_rd_q <= 1'b0;
    end else begin
      s2_rd_q <= s1_rd_i & ~kill_i;
    end
  end

  // Capture only words that belong to a read.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_data_q <= '0;
    end else if (s1_rd_i) begin
      s2_data_q <= rd_data_i;
    end
  end

  assign s2_rd_o   = s2_rd_q;
  assign s2_data_o = s2_data_q;

endmodule

// File: rtl/sram_rd_drive.sv
module sram_rd_drive #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              pipe_mode_i,
  input  logic              oe_i,
  input  logic              s1_rd_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              s2_rd_i,
  input  logic [DATA_W-1:0] s2_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] drive_en_o
);

  logic              active;
  logic [DATA_W-1:0] word;

  always_comb begin
    if (pipe_mode_i) begin
      active = s2_rd_i;
      word   = s2_data_i;
    end else begin
      active = s1_rd_i;
      word   = rd_data_i;
    end
  end

  assign valid_o = active;

  // Per-bit drive and data gating; oe_i acts without a clock.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign data_o[b]     = active & word[b];
    assign drive_en_o[b] = active & oe_i;
  end

endmodule

// File: rtl/sram_rd_out_path.sv
module sram_rd_out_path #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              oe_i,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] drive_en_o
);

  logic              s1_rd;
  logic              kill;
  logic              s2_rd;
  logic [DATA_W-1:0] s2_data;

  sram_rd_cmd_stage i_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .rd_i    (rd_i),
    .s1_rd_o (s1_rd),
    .kill_o  (kill)
  );

  sram_rd_out_reg #(.DATA_W(DATA_W)) i_oreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s1_rd_i   (s1_rd),
    .kill_i    (kill),
    .rd_data_i (rd_data_i),
    .s2_rd_o   (s2_rd),
    .s2_data_o (s2_data)
  );

  sram_rd_drive #(.DATA_W(DATA_W)) i_drv (
    .pipe_mode_i (pipe_mode_i),
    .oe_i        (oe_i),
    .s1_rd_i     (s1_rd),
    .rd_data_i   (rd_data_i),
    .s2_rd_i     (s2_rd),
    .s2_data_i   (s2_data),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .drive_en_o  (drive_en_o)
  );

endmodule

// File: rtl/sram_rd_out_path_chk.sv
module sram_rd_out_path_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pipe_mode_i,
  input logic              oe_i,
  input logic              sel_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] drive_en_o
);

  logic       is_rd, is_wr, is_ds, armed;
  logic [1:0] cnt_q;

  assign is_rd = sel_i & rd_i;
  assign is_wr = sel_i & ~rd_i;
  assign is_ds = ~sel_i;
  assign armed = (cnt_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= 2'd0;
    else if (cnt_q != 3) cnt_q <= cnt_q + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!valid_o && drive_en_o == '0 && data_o == '0); // R1
    end
  end

  AST_FT_READ_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && is_rd) |=> (pipe_mode_i || (valid_o && data_o == rd_data_i))); // R2

  AST_PIPE_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && pipe_mode_i && $past(pipe_mode_i) && valid_o) |->
      ($past(is_rd, 2) && !$past(is_wr) && data_o == $past(rd_data_i))); // R3

  AST_PIPE_DESEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && pipe_mode_i && is_ds && $past(is_rd)) |=> (valid_o || !pipe_mode_i)); // R5

  AST_FT_DESEL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && is_ds) |=> (!valid_o || pipe_mode_i)); // R6

  AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> !valid_o); // R7

  AST_DRIVE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o != '0) |-> (oe_i && valid_o && (&drive_en_o))); // R8

  AST_DATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (data_o == '0)); // R9

endmodule

bind sram_rd_out_path sram_rd_out_path_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pipe_mode_i (pipe_mode_i),
  .oe_i        (oe_i),
  .sel_i       (sel_i),
  .rd_i        (rd_i),
  .rd_data_i   (rd_data_i),
  .data_o      (data_o),
  .valid_o     (valid_o),
  .drive_en_o  (drive_en_o)
);

// File: tb/test_sram_rd_out_path.sv
module test_sram_rd_out_path;

  localparam int unsigned W = 32;
  localparam logic [W-1:0] JUNK = 32'hDEAD_BEEF;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pipe_mode_i = 1'b1;
  logic         oe_i = 1'b0;
  logic         sel_i = 1'b0;
  logic         rd_i = 1'b0;
  logic [W-1:0] rd_data_i = '0;
  logic [W-1:0] data_o;
  logic         valid_o;
  logic [W-1:0] drive_en_o;

  int n_run = 0;
  int n_fail = 0;

  sram_rd_out_path #(.DATA_W(W)) i_sram_rd_out_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pipe_mode_i (pipe_mode_i),
    .oe_i        (oe_i),
    .sel_i       (sel_i),
    .rd_i        (rd_i),
    .rd_data_i   (rd_data_i),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .drive_en_o  (drive_en_o)
  );

  always #2.5 clk_i = ~clk_i;

  initial begin
    #(200_000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Command for the next edge, array word for the current cycle, expected outputs now.
  task automatic cyc(input logic sel, input logic rd, input logic [W-1:0] arr,
                     input logic oe, input logic exp_v, input logic [W-1:0] exp_d,
                     input string tag);
    logic [W-1:0] ed;
    logic [W-1:0] ee;
    sel_i = sel; rd_i = rd; rd_data_i = arr; oe_i = oe;
    #1;
    ed = exp_v ? exp_d : '0;
    ee = (exp_v && oe) ? '1 : '0;
    chk(valid_o == exp_v, {tag, " valid"}, W'(valid_o), W'(exp_v));
    chk(data_o == ed, {tag, " data"}, data_o, ed);
    chk(drive_en_o == ee, {tag, " drive"}, drive_en_o, ee);
    @(posedge clk_i); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, JUNK, 1'b1, 1'b0, '0, "R9 idle");
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk_i);
    #1;
    sel_i = 1'b1; rd_i = 1'b1; rd_data_i = JUNK; oe_i = 1'b1;
    @(posedge clk_i); #1;
    chk(valid_o == 1'b0, "R1 valid in reset", W'(valid_o), '0);
    chk(data_o == '0, "R1 data in reset", data_o, '0);
    chk(drive_en_o == '0, "R1 drive in reset", drive_en_o, '0);
    sel_i = 1'b0; rd_i = 1'b0;
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
  endtask

  task automatic t_ft_burst;
    pipe_mode_i = 1'b0;
    idle(2);
    cyc(1, 1, JUNK,         1, 0, '0,           "R2 ft before data");
    cyc(1, 1, 32'hA000_0001, 1, 1, 32'hA000_0001, "R2 ft first word");
    cyc(1, 1, 32'hA000_0002, 1, 1, 32'hA000_0002, "R4 ft second word");
    cyc(1, 1, 32'hA000_0003, 1, 1, 32'hA000_0003, "R4 ft third word");
    cyc(0, 0, 32'hA000_0004, 1, 1, 32'hA000_0004, "R4 ft fourth word");
    cyc(0, 0, JUNK,         1, 0, '0,           "R6 ft off after deselect");
    idle(1);
  endtask

  task automatic t_pipe_burst;
    pipe_mode_i = 1'b1;
    idle(2);
    cyc(1, 1, JUNK,         1, 0, '0,           "R3 pipe before data");
    cyc(1, 1, 32'hB000_0001, 1, 0, '0,           "R3 pipe not early");
    cyc(1, 1, 32'hB000_0002, 1, 1, 32'hB000_0001, "R3 pipe first word");
    cyc(0, 0, 32'hB000_0003, 1, 1, 32'hB000_0002, "R4 pipe second word");
    cyc(0, 0, JUNK,         1, 1, 32'hB000_0003, "R5 pipe held after deselect");
    cyc(0, 0, JUNK,         1, 0, '0,           "R5 pipe off second edge");
    idle(1);
  endtask

  task automatic t_write;
    pipe_mode_i = 1'b1;
    idle(2);
    cyc(1, 1, JUNK,         1, 0, '0,           "R7 pipe read");
    cyc(1, 0, 32'hC000_0001, 1, 0, '0,           "R7 pipe write issued");
    cyc(1, 1, JUNK,         1, 0, '0,           "R7 pipe read discarded");
    cyc(0, 0, 32'hC000_0002, 1, 0, '0,           "R7 pipe write slot");
    cyc(0, 0, JUNK,         1, 1, 32'hC000_0002, "R7 pipe read after write");
    idle(2);
    pipe_mode_i = 1'b0;
    idle(1);
    cyc(1, 1, JUNK,         1, 0, '0,           "R7 ft read");
    cyc(1, 0, 32'hC100_0001, 1, 1, 32'hC100_0001, "R7 ft word before write");
    cyc(0, 0, JUNK,         1, 0, '0,           "R7 ft off after write");
    idle(1);
  endtask

  task automatic t_oe;
    pipe_mode_i = 1'b1;
    idle(2);
    cyc(1, 1, JUNK,         0, 0, '0,           "R8 read oe low");
    cyc(0, 0, 32'hD000_0001, 0, 0, '0,           "R8 capture oe low");
    sel_i = 1'b0; rd_i = 1'b0; oe_i = 1'b0; #1;
    chk(valid_o == 1'b1, "R8 valid with oe low", W'(valid_o), 1);
    chk(drive_en_o == '0, "R8 no drive with oe low", drive_en_o, '0);
    chk(data_o == 32'hD000_0001, "R8 data with oe low", data_o, 32'hD000_0001);
    oe_i = 1'b1; #1;
    chk(drive_en_o == '1, "R8 drive on without edge", drive_en_o, '1);
    oe_i = 1'b0; #1;
    chk(drive_en_o == '0, "R8 drive off without edge", drive_en_o, '0);
    @(posedge clk_i); #1;
    cyc(0, 0, JUNK,         1, 0, '0,           "R8 idle with oe high");
    idle(1);
  endtask

  initial begin
    t_reset();
    t_ft_burst();
    t_pipe_burst();
    t_write();
    t_oe();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule